// File: doc/BRIEF.md
# Result Latency Scoreboard

This block keeps a per-register record of when a pending result may be consumed. Load and floating-point add/multiply issue events load a small down-counter for their destination register. The counter's start value comes from the kind of operation. For loads it also depends on a signed-narrow flag, a cache-miss flag with a choice of two penalties, and the rule that load results become readable in strictly increasing cycle order. Each counter then decrements once per cycle. A register is readable when its counter reaches zero.

Up to four candidate instructions per cycle each present one source register index. For every slot the block returns two answers: whether an ordinary read may proceed, and whether a store-data read may proceed. A store-data read of a pending floating-point result never has to wait. A store-data read of a pending load result waits like any other read. A flush input drops every pending countdown and the load-ordering history. The block models timing only; it holds no data.

Timing convention: an operation presented on the issue inputs during cycle c is captured at the clock edge ending cycle c. "Readable L cycles after issue" means the ready outputs for that register first read 1 in cycle c+L.

Top module: `lat_scoreboard`

## Requirements
- R1: After reset, every register reads as ready on both `rd_ready` and `st_ready` for every query slot.
- R2: A load with no flags set makes its destination readable 2 cycles after issue.
- R3: A load with `ld_signed_narrow`=1 takes one extra cycle (3 cycles with no miss).
- R4: A load with `ld_miss`=1 adds 7 cycles when `ld_miss_long`=0 and 9 cycles when `ld_miss_long`=1. `ld_miss_long` has no effect when `ld_miss`=0.
- R5: A load's result never becomes readable earlier than one cycle after the previous load's result became readable.
- R6: An FP operation on either FP port (`fp_valid[k]`, destination `fp_dst[5k+4:5k]`) makes its destination readable 3 cycles after issue.
- R7: While a register waits on an FP result, `st_ready` for it is 1. While it waits on a load, `st_ready` equals `rd_ready`. `rd_ready`=1 always implies `st_ready`=1.
- R8: A later issue to a register replaces that register's pending countdown.
- R9: When a load and an FP operation target the same register in the same cycle, the load's countdown and kind are kept.
- R10: An active `flush` makes all registers ready in the following cycle and clears the load-ordering history, so the next load sees no ordering delay.
- R11: The four query slots are independent. Slot i takes its register index from `q_src[5i+4:5i]` and reports on `rd_ready[i]` and `st_ready[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Clear all pending countdowns and load history |
| ld_valid | input | 1 | Load issues this cycle |
| ld_dst | input | 5 | Load destination register |
| ld_signed_narrow | input | 1 | Load is signed and narrower than 64 bits |
| ld_miss | input | 1 | Load misses the first-level cache |
| ld_miss_long | input | 1 | Selects the longer miss penalty |
| fp_valid | input | 2 | FP add / multiply issue, one bit per port |
| fp_dst | input | 10 | FP destinations, 5 bits per port |
| q_src | input | 20 | Source register index per query slot |
| rd_ready | output | 4 | Ordinary read may proceed, per slot |
| st_ready | output | 4 | Store-data read may proceed, per slot |

## Verification
The assertions assume that issue inputs are known whenever `rst_n` is high. They also assume that flush is not held together with an issue the bench relies on, since flush wins. The FP-latency property only looks at the highest FP port, and only when no load names the same register in that cycle. The stimulus keeps within these limits: inputs change only on the falling edge and are cleared to zero between operations. Loads are spaced so that ordering delays come up only in the tests written to produce them, and flush is raised in a cycle with no issue.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
   typedef enum logic {
      SRC_FP   = 1'b0,
      SRC_LOAD = 1'b1
   } src_kind_e;
endpackage

// File: rtl/lsb_entry.sv
module lsb_entry
   import lsb_pkg::*;
#(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          set_en,
   input  logic [CW-1:0] set_cnt,
   input  src_kind_e     set_kind,
   output logic [CW-1:0] cnt_o,
   output src_kind_e     kind_o
);
   logic [CW-1:0] cnt_q;
   src_kind_e     kind_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         kind_q <= SRC_FP;
      end else if (flush) begin
         cnt_q  <= '0;
         kind_q <= SRC_FP;
      end else if (set_en) begin
         cnt_q  <= set_cnt;
         kind_q <= set_kind;
      end else if (cnt_q != '0) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign kind_o = kind_q;
endmodule

// File: rtl/lsb_ldorder.sv
module lsb_ldorder #(
   parameter int CW      = 4,
   parameter int LD_LAT  = 2,
   parameter int SGN_PEN = 1,
   parameter int MISS_S  = 7,
   parameter int MISS_L  = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          ld_valid,
   input  logic          ld_sn,
   input  logic          ld_miss,
   input  logic          ld_long,
   output logic [CW-1:0] ld_cnt,
   output logic [CW-1:0] last_o
);
   logic [CW-1:0] last_q;
   logic [CW-1:0] own;
   logic [CW-1:0] last_dec;
   logic [CW-1:0] chain;

   always_comb begin
      own = CW'(LD_LAT - 1);
      if (ld_sn)   own = own + CW'(SGN_PEN);
      if (ld_miss) own = own + (ld_long ? CW'(MISS_L) : CW'(MISS_S));
      last_dec = (last_q == '0) ? '0 : last_q - 1'b1;
      chain    = last_dec + 1'b1;
      ld_cnt   = (chain > own) ? chain : own;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          last_q <= '0;
      else if (flush)      last_q <= '0;
      else if (ld_valid)   last_q <= ld_cnt;
      else                 last_q <= last_dec;
   end

   assign last_o = last_q;
endmodule

// File: rtl/lsb_query.sv
module lsb_query
   import lsb_pkg::*;
#(
   parameter int NREG = 32,
   parameter int CW   = 4,
   parameter int NQ   = 4,
   parameter int RW   = 5
) (
   input  logic [NREG-1:0][CW-1:0] cnt_all,
   input  src_kind_e               kind_all [NREG],
   input  logic [NQ*RW-1:0]        q_src,
   output logic [NQ-1:0]           rd_ready,
   output logic [NQ-1:0]           st_ready
);
   for (genvar i = 0; i < NQ; i++) begin : g_slot
      logic [RW-1:0] idx;
      logic          zero;
      assign idx         = q_src[i*RW +: RW];
      assign zero        = (cnt_all[idx] == '0);
      assign rd_ready[i] = zero;
      assign st_ready[i] = zero || (kind_all[idx] != SRC_LOAD);
   end
endmodule

// File: rtl/lat_scoreboard.sv
module lat_scoreboard
   import lsb_pkg::*;
#(
   parameter int NREG    = 32,
   parameter int NQ      = 4,
   parameter int NFP     = 2,
   parameter int CW      = 4,
   parameter int LD_LAT  = 2,
   parameter int SGN_PEN = 1,
   parameter int MISS_S  = 7,
   parameter int MISS_L  = 9,
   parameter int FP_LAT  = 3,
   localparam int RW     = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               ld_valid,
   input  logic [RW-1:0]      ld_dst,
   input  logic               ld_signed_narrow,
   input  logic               ld_miss,
   input  logic               ld_miss_long,
   input  logic [NFP-1:0]     fp_valid,
   input  logic [NFP*RW-1:0]  fp_dst,
   input  logic [NQ*RW-1:0]   q_src,
   output logic [NQ-1:0]      rd_ready,
   output logic [NQ-1:0]      st_ready
);
   localparam int MISS_MAX = (MISS_L > MISS_S) ? MISS_L : MISS_S;
   localparam int LD_MAX   = LD_LAT + SGN_PEN + MISS_MAX;
   localparam int CNT_MAX  = (1 << CW) - 1;

   if (NREG < 2 || (1 << RW) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (LD_LAT < 1 || FP_LAT < 1) begin : g_bad_lat
      $error("latencies must be at least one cycle");
   end
   if (LD_MAX - 1 > CNT_MAX || FP_LAT - 1 > CNT_MAX) begin : g_bad_cw
      $error("CW too narrow for the longest latency");
   end
   if (NQ < 1 || NFP < 1) begin : g_bad_ports
      $error("need at least one query slot and one FP port");
   end

   logic [CW-1:0]           ld_cnt;
   logic [CW-1:0]           ld_last;
   logic [NREG-1:0][CW-1:0] cnt_all;
   src_kind_e               kind_all [NREG];

   lsb_ldorder #(
      .CW(CW), .LD_LAT(LD_LAT), .SGN_PEN(SGN_PEN),
      .MISS_S(MISS_S), .MISS_L(MISS_L)
   ) u_order (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .ld_valid (ld_valid),
      .ld_sn    (ld_signed_narrow),
      .ld_miss  (ld_miss),
      .ld_long  (ld_miss_long),
      .ld_cnt   (ld_cnt),
      .last_o   (ld_last)
   );

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic          set_en;
      logic [CW-1:0] set_cnt;
      src_kind_e     set_kind;

      // FP ports first (higher index last), then a load overrides
      always_comb begin
         set_en   = 1'b0;
         set_cnt  = '0;
         set_kind = SRC_FP;
         for (int k = 0; k < NFP; k++) begin
            if (fp_valid[k] && fp_dst[k*RW +: RW] == RW'(r)) begin
               set_en  = 1'b1;
               set_cnt = CW'(FP_LAT - 1);
            end
         end
         if (ld_valid && ld_dst == RW'(r)) begin
            set_en   = 1'b1;
            set_cnt  = ld_cnt;
            set_kind = SRC_LOAD;
         end
      end

      lsb_entry #(.CW(CW)) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (flush),
         .set_en   (set_en),
         .set_cnt  (set_cnt),
         .set_kind (set_kind),
         .cnt_o    (cnt_all[r]),
         .kind_o   (kind_all[r])
      );
   end

   lsb_query #(.NREG(NREG), .CW(CW), .NQ(NQ), .RW(RW)) u_query (
      .cnt_all  (cnt_all),
      .kind_all (kind_all),
      .q_src    (q_src),
      .rd_ready (rd_ready),
      .st_ready (st_ready)
   );
endmodule

// File: rtl/lsb_checker.sv
module lsb_checker #(
   parameter int NREG   = 32,
   parameter int NQ     = 4,
   parameter int NFP    = 2,
   parameter int CW     = 4,
   parameter int FP_LAT = 3,
   parameter int RW     = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    flush,
   input logic                    ld_valid,
   input logic [RW-1:0]           ld_dst,
   input logic [NFP-1:0]          fp_valid,
   input logic [NFP*RW-1:0]       fp_dst,
   input logic [NQ-1:0]           rd_ready,
   input logic [NQ-1:0]           st_ready,
   input logic [NREG-1:0][CW-1:0] cnt_all,
   input logic [CW-1:0]           ld_last
);
   localparam int HI = NFP - 1;

   logic [RW-1:0] fp_hi_dst;
   assign fp_hi_dst = fp_dst[HI*RW +: RW];

   // a flush empties every countdown and the ordering history
   assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt_all == '0) && (ld_last == '0));

   // a load is never readable in the cycle right after issue
   assert_load_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !flush) |=> (cnt_all[$past(ld_dst)] != '0));

   // load ordering history never moves backwards on a new load
   assert_load_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !flush) |=> (ld_last >= $past(ld_last)));

   // FP issue on the highest port loads the FP countdown
   assert_fp_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fp_valid[HI] && !flush && !(ld_valid && ld_dst == fp_hi_dst))
      |=> (cnt_all[$past(fp_hi_dst)] == CW'(FP_LAT - 1)));

   for (genvar i = 0; i < NQ; i++) begin : g_q
      // R7: ordinary readiness implies store-data readiness
      assert_store_dominates_R7: assert property (@(posedge clk) disable iff (!rst_n)
         rd_ready[i] |-> st_ready[i]);
   end
endmodule

bind lat_scoreboard lsb_checker #(
   .NREG(NREG), .NQ(NQ), .NFP(NFP), .CW(CW), .FP_LAT(FP_LAT), .RW(RW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .flush    (flush),
   .ld_valid (ld_valid),
   .ld_dst   (ld_dst),
   .fp_valid (fp_valid),
   .fp_dst   (fp_dst),
   .rd_ready (rd_ready),
   .st_ready (st_ready),
   .cnt_all  (cnt_all),
   .ld_last  (ld_last)
);

// File: tb/tb_lat_scoreboard.sv
module tb_lat_scoreboard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        ld_valid = 1'b0;
   logic [4:0]  ld_dst = '0;
   logic        ld_signed_narrow = 1'b0;
   logic        ld_miss = 1'b0;
   logic        ld_miss_long = 1'b0;
   logic [1:0]  fp_valid = '0;
   logic [9:0]  fp_dst = '0;
   logic [19:0] q_src = '0;
   logic [3:0]  rd_ready;
   logic [3:0]  st_ready;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lat_scoreboard dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .ld_valid(ld_valid), .ld_dst(ld_dst),
      .ld_signed_narrow(ld_signed_narrow), .ld_miss(ld_miss),
      .ld_miss_long(ld_miss_long), .fp_valid(fp_valid), .fp_dst(fp_dst),
      .q_src(q_src), .rd_ready(rd_ready), .st_ready(st_ready)
   );

   // vector: [8] fp, [7] fp port, [6] signed, [5] miss, [4] long, [3:0] latency
   localparam logic [8:0] VEC [0:8] = '{
      9'b0_0_0_0_0_0010,  // R2 plain load
      9'b0_0_1_0_0_0011,  // R3 signed narrow
      9'b0_0_0_1_0_1001,  // R4 short miss
      9'b0_0_0_1_1_1011,  // R4 long miss
      9'b0_0_1_1_1_1100,  // R3 R4 combined long
      9'b0_0_1_1_0_1010,  // R3 R4 combined short
      9'b0_0_0_0_1_0010,  // R4 long flag without miss
      9'b1_0_0_0_0_0011,  // R6 port 0
      9'b1_1_0_0_0_0011   // R6 port 1
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_q(input int slot, input int r);
      q_src[slot*5 +: 5] = 5'(r);
   endtask

   task automatic clear_issue();
      ld_valid = 1'b0; ld_signed_narrow = 1'b0; ld_miss = 1'b0;
      ld_miss_long = 1'b0; fp_valid = '0; flush = 1'b0;
   endtask

   // called at sample point k=1; returns first cycle count with rd_ready
   task automatic measure(input int slot, output int k);
      k = 1;
      while (!rd_ready[slot] && k < 30) begin
         @(negedge clk); #1;
         k++;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int k, ka, kb;
      logic [8:0] v;
      set_q(0, 0); set_q(1, 13); set_q(2, 27); set_q(3, 31);
      idle(3);
      #1;
      chk("R1 rd_ready in reset", rd_ready, 4'hF);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 rd_ready after reset", rd_ready, 4'hF);
      chk("R1 st_ready after reset", st_ready, 4'hF);

      // table walk
      for (int i = 0; i < 9; i++) begin
         v = VEC[i];
         @(negedge clk);
         set_q(0, 3 + i);
         if (v[8]) begin
            fp_valid[v[7]] = 1'b1;
            fp_dst[v[7]*5 +: 5] = 5'(3 + i);
         end else begin
            ld_valid = 1'b1; ld_dst = 5'(3 + i);
            ld_signed_narrow = v[6]; ld_miss = v[5]; ld_miss_long = v[4];
         end
         @(negedge clk); clear_issue(); #1;
         chk(v[8] ? "R7 st_ready pending FP" : "R7 st_ready pending load",
             st_ready[0], v[8] ? 1 : 0);
         measure(0, k);
         chk(v[8] ? "R6 FP latency" : "R2 R3 R4 load latency", k, v[3:0]);
         idle(3);
      end

      // R11: independent slots, mixed issue in one cycle
      @(negedge clk);
      set_q(0, 20); set_q(1, 21); set_q(2, 22); set_q(3, 23);
      fp_valid = 2'b11; fp_dst = {5'd21, 5'd20};
      ld_valid = 1'b1; ld_dst = 5'd22;
      @(negedge clk); clear_issue(); #1;
      chk("R11 rd_ready k1", rd_ready, 4'b1000);
      chk("R11 st_ready k1", st_ready, 4'b1011);
      @(negedge clk); #1;
      chk("R11 rd_ready k2", rd_ready, 4'b1100);
      @(negedge clk); #1;
      chk("R6 R11 rd_ready k3", rd_ready, 4'b1111);
      idle(3);

      // R5: plain load right behind a long miss
      @(negedge clk);
      set_q(0, 14); set_q(1, 15);
      ld_valid = 1'b1; ld_dst = 5'd14; ld_miss = 1'b1; ld_miss_long = 1'b1;
      @(negedge clk);
      clear_issue(); ld_valid = 1'b1; ld_dst = 5'd15;
      @(negedge clk); clear_issue(); #1;
      ka = 0; kb = 0;
      for (int n = 1; n < 30; n++) begin
         if (ka == 0 && rd_ready[0]) ka = n;
         if (kb == 0 && rd_ready[1]) kb = n;
         @(negedge clk); #1;
      end
      chk("R5 first load ready", ka, 10);
      chk("R5 second load ordered", kb, 11);
      idle(2);

      // R8: FP overwrite of a pending long miss
      @(negedge clk);
      set_q(0, 7);
      ld_valid = 1'b1; ld_dst = 5'd7; ld_miss = 1'b1; ld_miss_long = 1'b1;
      @(negedge clk);
      clear_issue(); fp_valid[0] = 1'b1; fp_dst[4:0] = 5'd7;
      @(negedge clk); clear_issue(); #1;
      chk("R8 st_ready after overwrite", st_ready[0], 1);
      measure(0, k);
      chk("R8 overwrite latency", k, 3);
      idle(14);

      // R9: load and FP same register same cycle
      @(negedge clk);
      set_q(0, 12);
      ld_valid = 1'b1; ld_dst = 5'd12; ld_miss = 1'b1;
      fp_valid[0] = 1'b1; fp_dst[4:0] = 5'd12;
      @(negedge clk); clear_issue(); #1;
      chk("R9 st_ready load kind kept", st_ready[0], 0);
      measure(0, k);
      chk("R9 load latency kept", k, 9);
      idle(3);

      // R10: flush clears pending and ordering history
      @(negedge clk);
      set_q(0, 9); set_q(1, 10);
      ld_valid = 1'b1; ld_dst = 5'd9; ld_miss = 1'b1; ld_miss_long = 1'b1;
      @(negedge clk);
      clear_issue(); flush = 1'b1;
      @(negedge clk);
      clear_issue(); #1;
      chk("R10 ready after flush", rd_ready[0], 1);
      ld_valid = 1'b1; ld_dst = 5'd10;
      @(negedge clk); clear_issue(); #1;
      measure(1, k);
      chk("R10 no ordering after flush", k, 2);
      idle(3);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule